// File: doc/BRIEF.md
# Switchable-Accuracy Unsigned Multiplier

An unsigned N-by-N multiplier whose partial-product reduction tree is built mostly from dual-mode 4:2 compressors. One runtime input, `approx_i`, goes to every compressor at the same time. With it low, each compressor works as an exact two-full-adder cell and the multiplier returns the true 2N-bit product. With it high, each compressor switches to a cheaper approximate function and the whole multiplier returns an approximate product. No error-recovery stage follows the tree.

AND gates form the partial products. The tree is a column-compression structure. In every stage, each column with four or more bits feeds groups of four bits into compressors. A leftover group of three bits goes to an exact full adder, and one or two leftover bits pass through unchanged. The carry-out of compressor k in a column drives the carry-in of compressor k in the next-higher column of the same stage. If that column has no such compressor, the carry-out becomes a plain bit there. The generator adds stages until no column holds more than two bits. A carry-propagate adder then sums the last two rows. The product can be registered at the output, which is the default.

The default approximate cell keeps two pair signals. Its sum output is the OR of the two pair XORs, its carry output is the OR of the two pair ANDs, and it ignores its carry-in and drives its carry-out to zero. This cell never overstates the weighted value of its inputs. A second variant, chosen by parameter, connects inputs straight through to the outputs for the lowest cost.

Top module: `dq_dadda_mul`

## Requirements
- R1: With `approx_i` = 0, `product_o` equals the unsigned product `a_i * b_i` as 2N bits for every operand pair, including 0, 1 and all-ones.
- R2: `product_o` shows the operands and mode sampled at the previous rising edge of `clk_i`. Input changes between edges leave it unchanged.
- R3: While `rst_ni` is low, `product_o` is zero.
- R4: With `approx_i` = 1 and either operand zero, `product_o` is zero.
- R5: With `approx_i` = 1 and either operand a power of two (exactly one bit set), `product_o` equals the exact product.
- R6: With `approx_i` = 1, `product_o` never exceeds the exact product of the same operands.
- R7: With `approx_i` = 1, a run of random operands gives at least one result below the exact product, so the mode really changes the arithmetic.
- R8: The mode takes effect on every edge with no memory. After an approximate cycle, the next exact-mode cycle gives the exact product of its own operands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for the output register |
| rst_ni | input | 1 | Active-low asynchronous reset |
| approx_i | input | 1 | 1 selects approximate compressors, 0 selects exact |
| a_i | input | N | Unsigned multiplicand |
| b_i | input | N | Unsigned multiplier |
| product_o | output | 2N | Product, registered when REG_OUT = 1 |

## Verification
The bench targets the operands that stress the tree in different ways. All-ones operands fill every column, so a compressor whose carry-out was dropped or sent to the wrong column gives a wrong exact result there. Zero and single-bit operands must pass through the approximate tree unchanged; a cell that lets its ignored carry-in through, or that distorts lone ones, would break those cases. Random approximate results are bounded above by the true product, which exposes a cell that overstates its inputs. Alternating modes on the same operands catches a mode path that is latched or delayed by a cycle.

// File: rtl/dq_mul_pkg.sv
package dq_mul_pkg;

  localparam int MAX_COLS = 128;
  localparam int MAX_STG  = 64;

  // bits left in one column after one reduction stage, given its height and the height of the column below
  function automatic int next_height(int hc, int hl);
    int n4, r, n4l, rl;
    n4  = hc / 4;
    r   = hc % 4;
    n4l = hl / 4;
    rl  = hl % 4;
    return n4 + n4l + ((n4l > n4) ? (n4l - n4) : 0) + ((r == 3) ? 1 : r) + ((rl == 3) ? 1 : 0);
  endfunction

  function automatic int init_height(int n, int c);
    if (c >= 2 * n - 1) return 0;
    return (c < n) ? c + 1 : 2 * n - 1 - c;
  endfunction

  function automatic int col_height(int n, int s, int c);
    int h  [MAX_COLS];
    int hn [MAX_COLS];
    for (int i = 0; i < MAX_COLS; i++) begin
      h[i]  = init_height(n, i);
      hn[i] = 0;
    end
    for (int st = 0; st < s; st++) begin
      for (int i = 0; i < 2 * n; i++) hn[i] = next_height(h[i], (i > 0) ? h[i-1] : 0);
      for (int i = 0; i < 2 * n; i++) h[i] = hn[i];
    end
    return h[c];
  endfunction

  function automatic int stage_count(int n);
    int mx;
    for (int st = 0; st < MAX_STG; st++) begin
      mx = 0;
      for (int i = 0; i < 2 * n; i++)
        if (col_height(n, st, i) > mx) mx = col_height(n, st, i);
      if (mx <= 2) return st;
    end
    return MAX_STG;
  endfunction

endpackage

// File: rtl/dq_compressor.sv
module dq_compressor #(
  parameter int VARIANT = 1  // 0: wire-through, 1: pair OR/AND
) (
  input  logic       approx_i,
  input  logic [3:0] x_i,
  input  logic       cin_i,
  output logic       sum_o,
  output logic       carry_o,
  output logic       cout_o
);

  logic s1, t2;
  logic ex_sum, ex_carry, ex_cout;
  logic ap_sum, ap_carry, ap_cout;

  // exact: two chained full adders
  assign s1       = x_i[0] ^ x_i[1] ^ x_i[2];
  assign ex_cout  = (x_i[0] ^ x_i[1]) ? x_i[2] : x_i[0];
  assign t2       = s1 ^ x_i[3];
  assign ex_sum   = t2 ^ cin_i;
  assign ex_carry = t2 ? cin_i : x_i[3];

  if (VARIANT == 0) begin : g_wire
    assign ap_sum   = x_i[0];
    assign ap_carry = x_i[3];
    assign ap_cout  = x_i[2];
  end else begin : g_pair
    assign ap_sum   = (x_i[0] ^ x_i[1]) | (x_i[2] ^ x_i[3]);
    assign ap_carry = (x_i[0] & x_i[1]) | (x_i[2] & x_i[3]);
    assign ap_cout  = 1'b0;
  end

  assign sum_o   = approx_i ? ap_sum   : ex_sum;
  assign carry_o = approx_i ? ap_carry : ex_carry;
  assign cout_o  = approx_i ? ap_cout  : ex_cout;

endmodule

// File: rtl/dq_pp_gen.sv
module dq_pp_gen #(
  parameter int N    = 8,
  parameter int MAXH = N + 4,
  parameter int W    = 2 * N
) (
  input  logic [N-1:0]    a_i,
  input  logic [N-1:0]    b_i,
  output logic [MAXH-1:0] col_o [W]
);

  for (genvar c = 0; c < W; c++) begin : g_col
    localparam int LO = (c - N + 1 > 0) ? c - N + 1 : 0;
    always_comb begin
      col_o[c] = '0;
      for (int i = 0; i < N; i++) begin
        if (c - i >= 0 && c - i < N) col_o[c][i - LO] = a_i[i] & b_i[c - i];
      end
    end
  end

endmodule

// File: rtl/dq_reduce_stage.sv
module dq_reduce_stage
  import dq_mul_pkg::*;
#(
  parameter int N       = 8,
  parameter int S       = 0,
  parameter int MAXH    = N + 4,
  parameter int W       = 2 * N,
  parameter int VARIANT = 1
) (
  input  logic            approx_i,
  input  logic [MAXH-1:0] col_i [W],
  output logic [MAXH-1:0] col_o [W]
);

  logic [MAXH-1:0] cry_w  [W];
  logic [MAXH-1:0] cout_w [W];
  logic            fa_c   [W];

  for (genvar c = 0; c < W; c++) begin : g_col
    localparam int H    = col_height(N, S, c);
    localparam int HL   = (c > 0) ? col_height(N, S, c - 1) : 0;
    localparam int N4   = H / 4;
    localparam int R    = H % 4;
    localparam int N4L  = HL / 4;
    localparam int RL   = HL % 4;
    localparam int CL   = (c > 0) ? c - 1 : 0;
    localparam int XTRA = (N4L > N4) ? N4L - N4 : 0;
    localparam int BASE = N4 + N4L + XTRA;

    logic [MAXH-1:0] sum_w;
    logic            fa_s;

    for (genvar k = 0; k < MAXH; k++) begin : g_cmp
      if (k < N4) begin : g_on
        logic cin;
        if (k < N4L) begin : g_cin
          assign cin = cout_w[CL][k];
        end else begin : g_nocin
          assign cin = 1'b0;
        end
        dq_compressor #(.VARIANT(VARIANT)) u_cmp (
          .approx_i (approx_i),
          .x_i      (col_i[c][4*k +: 4]),
          .cin_i    (cin),
          .sum_o    (sum_w[k]),
          .carry_o  (cry_w[c][k]),
          .cout_o   (cout_w[c][k])
        );
      end else begin : g_off
        assign sum_w[k]     = 1'b0;
        assign cry_w[c][k]  = 1'b0;
        assign cout_w[c][k] = 1'b0;
      end
    end

    if (R == 3) begin : g_fa
      assign {fa_c[c], fa_s} = 2'(col_i[c][4*N4]) + 2'(col_i[c][4*N4+1]) + 2'(col_i[c][4*N4+2]);
    end else begin : g_nofa
      assign fa_c[c] = 1'b0;
      assign fa_s    = 1'b0;
    end

    always_comb begin
      col_o[c] = '0;
      for (int k = 0; k < N4; k++)  col_o[c][k] = sum_w[k];
      for (int k = 0; k < N4L; k++) col_o[c][N4 + k] = cry_w[CL][k];
      // orphan carry-outs from below become plain bits here
      for (int k = 0; k < XTRA; k++) col_o[c][N4 + N4L + k] = cout_w[CL][N4 + k];
      if (R == 3) col_o[c][BASE] = fa_s;
      else for (int k = 0; k < R; k++) col_o[c][BASE + k] = col_i[c][4*N4 + k];
      if (RL == 3) col_o[c][BASE + ((R == 3) ? 1 : R)] = fa_c[CL];
    end
  end

endmodule

// File: rtl/dq_dadda_mul.sv
module dq_dadda_mul
  import dq_mul_pkg::*;
#(
  parameter int N           = 8,
  parameter bit REG_OUT     = 1'b1,
  parameter int APX_VARIANT = 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           approx_i,
  input  logic [N-1:0]   a_i,
  input  logic [N-1:0]   b_i,
  output logic [2*N-1:0] product_o
);

  localparam int W    = 2 * N;
  localparam int MAXH = N + 4;
  localparam int NST  = stage_count(N);

  logic [MAXH-1:0] lvl [NST+1][W];
  logic [W-1:0]    row0, row1, sum_full;

  dq_pp_gen #(.N(N), .MAXH(MAXH), .W(W)) u_pp (
    .a_i   (a_i),
    .b_i   (b_i),
    .col_o (lvl[0])
  );

  for (genvar s = 0; s < NST; s++) begin : g_stg
    dq_reduce_stage #(.N(N), .S(s), .MAXH(MAXH), .W(W), .VARIANT(APX_VARIANT)) u_stg (
      .approx_i (approx_i),
      .col_i    (lvl[s]),
      .col_o    (lvl[s+1])
    );
  end

  always_comb begin
    for (int c = 0; c < W; c++) begin
      row0[c] = lvl[NST][c][0];
      row1[c] = lvl[NST][c][1];
    end
  end

  // final carry-propagate adder; architecture left to synthesis
  assign sum_full = row0 + row1;

  if (REG_OUT) begin : g_reg
    logic [W-1:0] prod_q;
    logic         seen_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        prod_q <= '0;
        seen_q <= 1'b0;
      end else begin
        prod_q <= sum_full;
        seen_q <= 1'b1;
      end
    end
    assign product_o = prod_q;

    // R1
    exact_prod_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (seen_q && !$past(approx_i)) |-> (product_o == W'(W'($past(a_i)) * W'($past(b_i)))));

    // R3
    rst_zero_chk: assert property (@(posedge clk_i) !rst_ni |-> (product_o == '0));

    if (APX_VARIANT == 1) begin : g_apx_chk
      // R4
      apx_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (seen_q && $past(approx_i) && ($past(a_i) == '0 || $past(b_i) == '0)) |-> (product_o == '0));

      // R5
      apx_pow2_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (seen_q && $past(approx_i) && ($countones($past(a_i)) == 1 || $countones($past(b_i)) == 1))
        |-> (product_o == W'(W'($past(a_i)) * W'($past(b_i)))));

      // R6
      apx_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (seen_q && $past(approx_i)) |-> (product_o <= W'(W'($past(a_i)) * W'($past(b_i)))));
    end
  end else begin : g_comb
    assign product_o = sum_full;
  end

endmodule

// File: tb/dq_dadda_mul_test.sv
module dq_dadda_mul_test;

  localparam int N = 8;
  localparam int W = 2 * N;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b1;
  logic         approx_i = 1'b0;
  logic [N-1:0] a_i = '0;
  logic [N-1:0] b_i = '0;
  logic [W-1:0] product_o;

  int  n_tests = 0;
  int  n_fail  = 0;
  bit  done    = 1'b0;
  int  diff_cnt = 0;
  int  err_cnt  = 0;
  real err_sum  = 0.0;

  dq_dadda_mul #(.N(N), .REG_OUT(1'b1), .APX_VARIANT(1)) uut (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .approx_i  (approx_i),
    .a_i       (a_i),
    .b_i       (b_i),
    .product_o (product_o)
  );

  always #4 clk_i = ~clk_i;

  function automatic logic [W-1:0] exact_mul(logic [N-1:0] a, logic [N-1:0] b);
    return W'(W'(a) * W'(b));
  endfunction

  task automatic check(string req, bit ok, logic [W-1:0] act, logic [W-1:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  // entered at a falling edge; leaves at the next falling edge with the result registered
  task automatic apply(logic [N-1:0] a, logic [N-1:0] b, logic m);
    a_i = a;
    b_i = b;
    approx_i = m;
    @(negedge clk_i);
  endtask

  task automatic exact_case(logic [N-1:0] a, logic [N-1:0] b);
    apply(a, b, 1'b0);
    check("R1", product_o == exact_mul(a, b), product_o, exact_mul(a, b));
  endtask

  initial begin
    logic [N-1:0] corners [6];
    logic [N-1:0] ra, rb;
    logic [W-1:0] prev;
    int unused_seed;
    corners[0] = '0;   corners[1] = 8'd1;  corners[2] = '1;
    corners[3] = 8'h80; corners[4] = 8'h55; corners[5] = 8'hAA;
    unused_seed = $urandom(32'h1d2b);

    #1 rst_ni = 1'b0;
    a_i = 8'hFF; b_i = 8'hFF;
    repeat (3) @(negedge clk_i);
    // R3
    check("R3", product_o == '0, product_o, '0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 corners
    foreach (corners[i]) foreach (corners[j]) exact_case(corners[i], corners[j]);
    // R1 random
    for (int i = 0; i < 1500; i++) exact_case(N'($urandom), N'($urandom));

    // R2: mid-cycle input change leaves output alone
    exact_case(8'd200, 8'd17);
    prev = product_o;
    a_i = 8'd3; b_i = 8'd5;
    #2;
    check("R2", product_o == prev, product_o, prev);
    @(negedge clk_i);
    check("R2", product_o == exact_mul(8'd3, 8'd5), product_o, exact_mul(8'd3, 8'd5));

    // R4: zero operand in approximate mode
    for (int i = 0; i < 20; i++) begin
      ra = N'($urandom);
      apply(ra, '0, 1'b1);
      check("R4", product_o == '0, product_o, '0);
      apply('0, ra, 1'b1);
      check("R4", product_o == '0, product_o, '0);
    end

    // R5: power-of-two operand in approximate mode
    for (int sh = 0; sh < N; sh++) begin
      for (int i = 0; i < 4; i++) begin
        ra = (i == 0) ? '1 : N'($urandom);
        rb = N'(1) << sh;
        apply(ra, rb, 1'b1);
        check("R5", product_o == exact_mul(ra, rb), product_o, exact_mul(ra, rb));
        apply(rb, ra, 1'b1);
        check("R5", product_o == exact_mul(rb, ra), product_o, exact_mul(rb, ra));
      end
    end

    // R6 / R7: random approximate products
    for (int i = 0; i < 600; i++) begin
      ra = N'($urandom);
      rb = N'($urandom);
      apply(ra, rb, 1'b1);
      check("R6", product_o <= exact_mul(ra, rb), product_o, exact_mul(ra, rb));
      if (product_o != exact_mul(ra, rb)) diff_cnt++;
      if (exact_mul(ra, rb) != '0) begin
        err_sum += (real'(exact_mul(ra, rb)) - real'(product_o)) / real'(exact_mul(ra, rb));
        err_cnt++;
      end
    end
    // R7
    check("R7", diff_cnt > 0, W'(diff_cnt), W'(1));

    // R8: alternate modes each cycle on full-height operands
    for (int i = 0; i < 6; i++) begin
      apply('1, '1, 1'b1);
      check("R6", product_o <= exact_mul('1, '1), product_o, exact_mul('1, '1));
      apply('1, '1, 1'b0);
      check("R8", product_o == exact_mul('1, '1), product_o, exact_mul('1, '1));
    end

    if (err_cnt > 0)
      $display("[TB] approximate mode mean relative error %f over %0d samples", err_sum / err_cnt, err_cnt);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule